// File: doc/BRIEF.md
# Stack Pop Unit with Segment Selector Checks

This block carries out one stack pop. On a request it captures the current stack pointer and the pop attributes, then issues a memory read at the current pointer. When the data returns it works out the advanced pointer and the value to write back. If the destination is a segment register, it checks the popped selector against descriptor attributes that the caller supplies with the data. The result is either a writeback with a pointer update or an exception code with no state change.

Illegal combinations are decoded when the request arrives, and they complete in one cycle with no memory traffic. These are a code-segment destination, a forbidden operand size, and a legacy-only segment register used in 64-bit mode. The caller holds the request attributes valid in the request cycle. It drives the descriptor attributes together with the returned data.

Top module: `stack_pop_unit`

## Requirements
- R1: A non-faulting pop issues `mem_rd` with `mem_addr` equal to the pointer form chosen by the stack width. That is `sp_in[15:0]` or `sp_in[31:0]` zero-extended, or all 64 bits. `mem_rd` and `mem_addr` hold steady until `mem_valid`.
- R2: The pointer advances by 2, 4 or 8 for `op_size` codes 0 (16-bit), 1 (32-bit) and 2 (64-bit).
- R3: `stk_size` codes 0, 1 and 2 update the low 16, low 32 or all 64 pointer bits. The updated part wraps within its width, and the bits above it keep their old value. In 64-bit mode `stk_size` is ignored and the full 64-bit pointer is used.
- R4: Exception code 1 (invalid opcode) completes one cycle after the request, with no memory read, in any of these cases:
  - the destination is CS (code 6) or the reserved code 7;
  - `op_size` is 3;
  - `op_size` is 1 in 64-bit mode;
  - `op_size` is 2 outside 64-bit mode;
  - `stk_size` is 2 or more outside 64-bit mode;
  - the destination is DS (1), ES (2) or SS (3) in 64-bit mode.
  This check takes priority over all descriptor checks.
- R5: A general-register pop (`dest` 0) writes back the popped data zero-extended from the operand size.
- R6: A null selector (bits 15:2 all zero) popped into DS, ES (2), FS (4) or GS (5) loads without fault, whatever the descriptor says. The writeback is the 16-bit selector zero-extended.
- R7: A null selector popped into SS gives exception code 2 (general protection).
- R8: A non-null SS load gives code 2 in any of these cases: the selector RPL (bits 1:0) differs from `cpl`, `desc_dpl` differs from `cpl`, the descriptor is not data, or it is not writable.
- R9: A non-null DS/ES/FS/GS load gives code 2 in either of two cases. The first is when the segment is code that is not readable. The second is when the segment is data or non-conforming code and RPL or `cpl` exceeds `desc_dpl`. Conforming readable code skips the privilege test.
- R10: A non-null selector that passes the R8/R9 checks but is not present gives code 3 (segment not present), or code 4 (stack fault) for SS. The R8/R9 faults take priority.
- R11: `done` pulses one cycle per pop. With a non-zero exception code, neither `sp_we` nor `wb_we` is asserted. On success both are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pop_req | input | 1 | Start a pop (accepted when idle) |
| mode64 | input | 1 | 1 = 64-bit mode |
| op_size | input | 2 | 0=16, 1=32, 2=64-bit operand |
| stk_size | input | 2 | 0=16, 1=32, 2=64-bit stack pointer form |
| dest | input | 3 | 0 GPR, 1 DS, 2 ES, 3 SS, 4 FS, 5 GS, 6 CS, 7 reserved |
| cpl | input | 2 | Current privilege level |
| sp_in | input | 64 | Current stack pointer |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 64 | Read address |
| mem_size | output | 2 | Read size, same code as op_size |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| desc_present | input | 1 | Descriptor present |
| desc_is_data | input | 1 | 1 = data segment, 0 = code segment |
| desc_rw | input | 1 | Writable (data) or readable (code) |
| desc_conform | input | 1 | Conforming code segment |
| desc_dpl | input | 2 | Descriptor privilege level |
| done | output | 1 | Result valid pulse |
| exc | output | 3 | 0 none, 1 invalid opcode, 2 GP, 3 not present, 4 stack fault |
| sp_we | output | 1 | Stack pointer update valid |
| sp_out | output | 64 | New stack pointer |
| wb_we | output | 1 | Destination writeback valid |
| wb_data | output | 64 | Writeback value |

## Verification
General-register pops are run at every operand size and stack width. The pointers are placed near a 16-bit or 32-bit boundary, so the tests show wrap within the updated part apart from carry into the upper bits. They also show masking of the writeback apart from passing the full word. Illegal requests are mixed with legal ones, which shows that the invalid-opcode path never reaches memory. Selector pops go through null, privilege-mismatch, wrong-type and not-present descriptors one at a time, plus one descriptor that fails two checks at once. This separates the GP, not-present and stack-fault codes and confirms their priority order.

// File: rtl/stack_pop_unit.sv
module stack_pop_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pop_req,
  input  logic        mode64,
  input  logic [1:0]  op_size,
  input  logic [1:0]  stk_size,
  input  logic [2:0]  dest,
  input  logic [1:0]  cpl,
  input  logic [63:0] sp_in,
  output logic        mem_rd,
  output logic [63:0] mem_addr,
  output logic [1:0]  mem_size,
  input  logic        mem_valid,
  input  logic [63:0] mem_rdata,
  input  logic        desc_present,
  input  logic        desc_is_data,
  input  logic        desc_rw,
  input  logic        desc_conform,
  input  logic [1:0]  desc_dpl,
  output logic        done,
  output logic [2:0]  exc,
  output logic        sp_we,
  output logic [63:0] sp_out,
  output logic        wb_we,
  output logic [63:0] wb_data
);
  localparam logic [2:0] X_NONE = 3'd0, X_UD = 3'd1, X_GP = 3'd2, X_NP = 3'd3, X_SS = 3'd4;
  localparam logic [2:0] D_GPR = 3'd0, D_SS = 3'd3;

  logic        busy;
  logic [1:0]  osz_q, ssz_q, cpl_q;
  logic [2:0]  dst_q;
  logic [63:0] sp_q;

  logic ud;
  assign ud = (dest >= 3'd6) || (op_size == 2'd3) ||
              (mode64 && op_size == 2'd1) || (!mode64 && op_size == 2'd2) ||
              (!mode64 && stk_size[1]) ||
              (mode64 && dest >= 3'd1 && dest <= 3'd3);

  assign mem_rd   = busy;
  assign mem_size = osz_q;
  always_comb
    case (ssz_q)
      2'd0:    mem_addr = {48'b0, sp_q[15:0]};
      2'd1:    mem_addr = {32'b0, sp_q[31:0]};
      default: mem_addr = sp_q;
    endcase

  logic [63:0] inc, nsp;
  assign inc = 64'd2 << osz_q;
  always_comb
    case (ssz_q)
      2'd0:    nsp = {sp_q[63:16], sp_q[15:0] + inc[15:0]};
      2'd1:    nsp = {sp_q[63:32], sp_q[31:0] + inc[31:0]};
      default: nsp = sp_q + inc;
    endcase

  logic [15:0] sel;
  logic [1:0]  rpl;
  logic        nul;
  assign sel = mem_rdata[15:0];
  assign rpl = sel[1:0];
  assign nul = (sel[15:2] == 14'd0);

  logic [63:0] wb;
  always_comb
    if (dst_q != D_GPR) wb = {48'b0, sel};
    else case (osz_q)
      2'd0:    wb = {48'b0, mem_rdata[15:0]};
      2'd1:    wb = {32'b0, mem_rdata[31:0]};
      default: wb = mem_rdata;
    endcase

  logic [2:0] flt;
  always_comb begin
    flt = X_NONE;
    if (dst_q == D_SS) begin
      if (nul) flt = X_GP;
      else if (rpl != cpl_q || desc_dpl != cpl_q || !desc_is_data || !desc_rw) flt = X_GP;
      else if (!desc_present) flt = X_SS;
    end else if (dst_q != D_GPR && !nul) begin
      if (!desc_is_data && !desc_rw) flt = X_GP;
      else if ((desc_is_data || !desc_conform) && (rpl > desc_dpl || cpl_q > desc_dpl)) flt = X_GP;
      else if (!desc_present) flt = X_NP;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; osz_q <= '0; ssz_q <= '0; cpl_q <= '0; dst_q <= '0; sp_q <= '0;
      done <= 1'b0; exc <= X_NONE; sp_we <= 1'b0; wb_we <= 1'b0;
      sp_out <= '0; wb_data <= '0;
    end else begin
      done <= 1'b0; sp_we <= 1'b0; wb_we <= 1'b0;
      if (!busy && pop_req) begin
        osz_q <= op_size;
        ssz_q <= mode64 ? 2'd2 : stk_size;
        dst_q <= dest;
        cpl_q <= cpl;
        sp_q  <= sp_in;
        if (ud) begin
          done <= 1'b1;
          exc  <= X_UD;
        end else busy <= 1'b1;
      end else if (busy && mem_valid) begin
        busy <= 1'b0;
        done <= 1'b1;
        exc  <= flt;
        if (flt == X_NONE) begin
          sp_we   <= 1'b1;
          wb_we   <= 1'b1;
          sp_out  <= nsp;
          wb_data <= wb;
        end
      end
    end

  assert_ud_noread_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pop_req && ud) |=> (done && exc == X_UD && !mem_rd));
  assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_valid) |=> (mem_rd && $stable(mem_addr)));
  assert_exc_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exc != X_NONE) |-> (!sp_we && !wb_we));
  assert_ok_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exc == X_NONE) |-> (sp_we && wb_we));
  assert_upper_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && ssz_q == 2'd0) |-> (sp_out[63:16] == sp_q[63:16]));
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd);
endmodule

// File: tb/sim_stack_pop_unit.sv
module sim_stack_pop_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic pop_req = 0, mode64 = 0;
  logic [1:0] op_size = 0, stk_size = 0, cpl = 0, desc_dpl = 0;
  logic [2:0] dest = 0;
  logic [63:0] sp_in = 0, mem_rdata = 0;
  logic mem_valid = 0, desc_present = 0, desc_is_data = 0, desc_rw = 0, desc_conform = 0;
  logic mem_rd, done, sp_we, wb_we;
  logic [63:0] mem_addr, sp_out, wb_data;
  logic [1:0] mem_size;
  logic [2:0] exc;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_pop_unit u0 (.*);

  typedef struct { logic [2:0] exc; logic [63:0] sp; logic [63:0] wb; string tag; } exp_t;
  exp_t sb[$];
  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n && done) begin
    if (sb.size() == 0) chk(0, "unexpected done R11", 64'd1, 64'd0);
    else begin
      exp_t e;
      e = sb.pop_front();
      chk(exc == e.exc, {e.tag, " exc"}, 64'(exc), 64'(e.exc));
      chk(sp_we == (e.exc == 0) && wb_we == (e.exc == 0), {e.tag, " we R11"},
          64'({sp_we, wb_we}), 64'({2{e.exc == 0}}));
      if (e.exc == 0) begin
        chk(sp_out == e.sp, {e.tag, " sp"}, sp_out, e.sp);
        chk(wb_data == e.wb, {e.tag, " wb"}, wb_data, e.wb);
      end
    end
  end

  task automatic pop(input bit m64, input logic [1:0] osz, input logic [1:0] ssz,
                     input logic [2:0] dst, input logic [1:0] pl, input logic [63:0] sp,
                     input logic [63:0] rdata, input bit pres, input bit isd, input bit rw,
                     input bit conf, input logic [1:0] dpl, input logic [63:0] exp_addr,
                     input logic [2:0] eexc, input logic [63:0] esp, input logic [63:0] ewb,
                     input string tag);
    exp_t e;
    e.exc = eexc; e.sp = esp; e.wb = ewb; e.tag = tag;
    @(negedge clk);
    mode64 = m64; op_size = osz; stk_size = ssz; dest = dst; cpl = pl; sp_in = sp;
    pop_req = 1;
    sb.push_back(e);
    @(negedge clk);
    pop_req = 0;
    if (eexc == 3'd1) begin
      chk(mem_rd == 0, {tag, " no read R4"}, 64'(mem_rd), 64'd0);
    end else begin
      for (int i = 0; i < 20 && !mem_rd; i++) @(negedge clk);
      chk(mem_rd && mem_addr == exp_addr, {tag, " addr R1"}, mem_addr, exp_addr);
      mem_rdata = rdata; desc_present = pres; desc_is_data = isd; desc_rw = rw;
      desc_conform = conf; desc_dpl = dpl; mem_valid = 1;
      @(negedge clk);
      mem_valid = 0;
    end
    for (int i = 0; i < 20 && sb.size() != 0; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0 && mem_rd == 0 && sp_we == 0 && wb_we == 0, "reset R11", 64'({done, mem_rd}), 64'd0);
    rst_n = 1;
    // R2 R3 R5: 16-bit wrap keeps upper bits
    pop(0, 0, 0, 0, 0, 64'h1111_2222_3333_FFFE, 64'hAAAA_BBBB_CCCC_1234, 0, 0, 0, 0, 0,
        64'h0000_0000_0000_FFFE, 0, 64'h1111_2222_3333_0000, 64'h1234, "gpr16 R3");
    pop(0, 1, 1, 0, 0, 64'h5555_0000_FFFF_FFFC, 64'h1234_5678_DEAD_BEEF, 0, 0, 0, 0, 0,
        64'h0000_0000_FFFF_FFFC, 0, 64'h5555_0000_0000_0000, 64'hDEAD_BEEF, "gpr32 R5");
    pop(0, 0, 1, 0, 0, 64'h1000, 64'hFFFF_FFFF_FFFF_ABCD, 0, 0, 0, 0, 0,
        64'h1000, 0, 64'h1002, 64'hABCD, "op16 stk32 R2");
    pop(1, 2, 0, 0, 0, 64'h0000_7FFF_FFFF_FFF8, 64'hFEDC_BA98_7654_3210, 0, 0, 0, 0, 0,
        64'h0000_7FFF_FFFF_FFF8, 0, 64'h0000_8000_0000_0000, 64'hFEDC_BA98_7654_3210, "m64 stk ignored R3");
    pop(1, 0, 2, 0, 0, 64'h100, 64'hFEDC_BA98_7654_3210, 0, 0, 0, 0, 0,
        64'h100, 0, 64'h102, 64'h3210, "m64 op16 R2");
    // R4
    pop(1, 1, 2, 0, 0, 64'h100, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "m64 op32 R4");
    pop(1, 2, 2, 1, 0, 64'h100, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "m64 DS R4");
    pop(0, 0, 0, 6, 0, 64'h100, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "CS R4");
    pop(0, 2, 0, 0, 0, 64'h100, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "legacy op64 R4");
    // R6
    pop(1, 2, 2, 4, 3, 64'h300, 64'hFFFF_FFFF_FFFF_0003, 0, 0, 0, 0, 0,
        64'h300, 0, 64'h308, 64'h3, "FS null R6");
    pop(0, 0, 0, 1, 0, 64'h20, 64'h0, 0, 0, 0, 0, 0, 64'h20, 0, 64'h22, 64'h0, "DS null R6");
    // R7 R8 R10 SS
    pop(0, 1, 1, 3, 0, 64'h200, 64'h2, 1, 1, 1, 0, 0, 64'h200, 2, 0, 0, "SS null R7");
    pop(0, 1, 1, 3, 0, 64'h200, 64'hABCD_0000_0000_0010, 1, 1, 1, 0, 0,
        64'h200, 0, 64'h204, 64'h10, "SS ok R8");
    pop(0, 1, 1, 3, 0, 64'h200, 64'h11, 1, 1, 1, 0, 0, 64'h200, 2, 0, 0, "SS rpl R8");
    pop(0, 1, 1, 3, 0, 64'h200, 64'h10, 1, 1, 0, 0, 0, 64'h200, 2, 0, 0, "SS ro R8");
    pop(0, 1, 1, 3, 0, 64'h200, 64'h10, 0, 1, 1, 0, 0, 64'h200, 4, 0, 0, "SS np R10");
    // R9 R10 DS/ES/GS
    pop(0, 0, 0, 1, 0, 64'h40, 64'h18, 1, 0, 0, 0, 0, 64'h40, 2, 0, 0, "DS exec-only R9");
    pop(0, 0, 0, 1, 3, 64'h40, 64'h13, 1, 1, 1, 0, 0, 64'h40, 2, 0, 0, "DS priv R9");
    pop(0, 0, 0, 1, 3, 64'h40, 64'h13, 1, 0, 1, 1, 0, 64'h40, 0, 64'h42, 64'h13, "DS conform R9");
    pop(0, 0, 0, 2, 0, 64'h40, 64'h20, 0, 1, 1, 0, 0, 64'h40, 3, 0, 0, "ES np R10");
    pop(1, 2, 2, 5, 0, 64'h40, 64'h23, 0, 1, 1, 0, 0, 64'h40, 2, 0, 0, "GS gp-first R10");
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "all results seen R11", 64'(sb.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule